// File: doc/BRIEF.md
# Interrupt Acceptance and Priority-Level Sequencer

This block decides when a small 16-bit processor core takes an interrupt and how long the entry sequence lasts. It waits at an instruction boundary, signalled by a completion input. There it picks one request from three groups. The first group is a set of maskable sources, each carrying a 3-bit priority. The second is four forcing sources: NMI, watchdog, clock-stop detection and supply-droop detection. The third is four level-preserving sources: software trap, debug break, single-step and address match. The block then runs the entry sequence for a computed number of cycles.

The sequence length has a base of 18 cycles. It grows by one cycle for each odd operand among the vector address and the stack pointer, and by a penalty that depends on the source. The processor interrupt priority level (IPL) is updated according to the class of the winner. An acknowledge pulse reports which source won, so that the requester can withdraw it. A start pulse in the last sequence cycle lets the first handler instruction issue.

Top module: `irq_accept_seq`

## Requirements
- R1: A request is accepted only on the clock edge where `insn_done` is high while the block is idle; `ack` is high in the cycle right after that edge. However long `insn_done` stays low (30 cycles for the slowest divide), no request is taken.
- R2: The sequence lasts 18 cycles with `vec_odd`=0 and `sp_odd`=0, 19 cycles with exactly one of them high, and 20 cycles with both high. `busy` is high for exactly that many cycles, and the first of them carries `ack`.
- R3: An accepted debug break (ID 4) adds 2 cycles to the R2 length. Single-step (ID 5) and address match (ID 6) each add 1 cycle. No other source adds cycles.
- R4: When maskable source i (ID 8+i) is accepted, `ipl` becomes that source's priority `mask_prio[3i+2:3i]` in the ack cycle.
- R5: When NMI (ID 0), watchdog (ID 1), clock-stop (ID 2) or supply-droop (ID 3) is accepted, `ipl` becomes 7.
- R6: When debug break, single-step, address match or software trap (ID 7) is accepted, `ipl` keeps its value.
- R7: A maskable request takes part only if `gie`=1 and its priority is strictly greater than `ipl`. Requests bits 0..7 of `spec_req` ignore both `gie` and `ipl`. An ineligible request at a boundary produces no `ack` and leaves `busy` low.
- R8: Among simultaneous requests, the winner is the lowest-set bit of `spec_req`. Bit order is 0 NMI, 1 watchdog, 2 clock-stop, 3 supply-droop, 4 debug break, 5 single-step, 6 address match, 7 software trap. If no bit is set, the winner is the eligible maskable source with the highest priority, and the lowest index wins a tie.
- R9: `ack` is a one-cycle pulse. `handler_start` is a one-cycle pulse in the last `busy` cycle, and `busy` is low in the following cycle.
- R10: While `busy` is high, `insn_done` and new requests have no effect. A request that is still pending is taken only at the next `insn_done` after the sequence ends.
- R11: Synchronous reset sets `ipl` to 0 and clears `busy`, `ack` and `handler_start` in the cycle after reset is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| insn_done | input | 1 | Current instruction completes this cycle (boundary) |
| gie | input | 1 | Global enable for maskable requests |
| spec_req | input | 8 | Non-maskable requests, bit index = arbitration rank and ID |
| mask_req | input | NUM_MASK (8) | Maskable request lines |
| mask_prio | input | 3*NUM_MASK (24) | Priority of each maskable source, 3 bits per source |
| vec_odd | input | 1 | Vector address of the winner is odd |
| sp_odd | input | 1 | Stack pointer is odd |
| busy | output | 1 | Entry sequence in progress |
| ack | output | 1 | One-cycle pulse at sequence start |
| ack_id | output | ID_W (4) | ID of the accepted source, valid with `ack` |
| ipl | output | 3 | Current interrupt priority level |
| handler_start | output | 1 | Last sequence cycle; first handler instruction may issue |

## Verification
The bench holds `insn_done` high for exactly one cycle and drives inputs on falling edges. `ack`, `ack_id` and the new `ipl` are then due at the falling edge one clock later, and the bench samples them there. `handler_start` is due exactly N-1 clocks after `ack`, where N is the length from R2 and R3, and `busy` falls on the clock after that. A scoreboard queue holds the expected ID, level and length of each sequence. A monitor counts `busy` cycles from each `ack` up to `handler_start`. Any `ack` for which no entry was queued is a failure, and this catches requests that were wrongly taken during a sequence or while ineligible.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;

    localparam int NUM_SPEC  = 8;
    localparam int PRIO_W    = 3;
    localparam int MIDX_W    = 6;

    typedef logic [PRIO_W-1:0] prio_t;
    localparam prio_t PRIO_TOP = prio_t'(7);

    // Bit index in spec_req equals arbitration rank and source ID
    typedef enum logic [2:0] {
        SRC_NMI    = 3'd0,
        SRC_WDOG   = 3'd1,
        SRC_CLKSTP = 3'd2,
        SRC_DROOP  = 3'd3,
        SRC_DBG    = 3'd4,
        SRC_STEP   = 3'd5,
        SRC_AMATCH = 3'd6,
        SRC_TRAP   = 3'd7
    } spec_src_e;

    typedef enum logic [1:0] {
        CLS_LOAD  = 2'd0,
        CLS_FORCE = 2'd1,
        CLS_KEEP  = 2'd2
    } ipl_cls_e;

    typedef struct packed {
        logic              hit;
        logic              is_mask;
        spec_src_e         spec;
        logic [MIDX_W-1:0] midx;
        prio_t             prio;
    } arb_win_t;

    function automatic int src_penalty(input spec_src_e s);
        case (s)
            SRC_DBG:              return 2;
            SRC_STEP, SRC_AMATCH: return 1;
            default:              return 0;
        endcase
    endfunction

    function automatic ipl_cls_e win_class(input arb_win_t w);
        if (w.is_mask)
            return CLS_LOAD;
        else if (w.spec inside {SRC_NMI, SRC_WDOG, SRC_CLKSTP, SRC_DROOP})
            return CLS_FORCE;
        else
            return CLS_KEEP;
    endfunction

    function automatic int entry_len(input int base, input logic vodd,
                                     input logic sodd, input arb_win_t w);
        int n;
        n = base + int'(vodd) + int'(sodd);
        if (!w.is_mask)
            n = n + src_penalty(w.spec);
        return n;
    endfunction

endpackage

// File: rtl/irq_arbiter.sv
module irq_arbiter
    import irq_seq_pkg::*;
#(
    parameter int NUM_MASK = 8
) (
    input  logic [NUM_SPEC-1:0]        spec_req,
    input  logic [NUM_MASK-1:0]        mask_req,
    input  logic [NUM_MASK*PRIO_W-1:0] mask_prio,
    input  logic                       gie,
    input  prio_t                      cur_ipl,
    output arb_win_t                   win
);

    logic [NUM_MASK-1:0] elig;

    generate
        for (genvar g = 0; g < NUM_MASK; g++) begin : g_elig
            assign elig[g] = mask_req[g] && gie &&
                             (mask_prio[g*PRIO_W +: PRIO_W] > cur_ipl);
        end
    endgenerate

    always_comb begin
        logic  m_found;
        prio_t m_best;
        logic [MIDX_W-1:0] m_idx;
        m_found = 1'b0;
        m_best  = '0;
        m_idx   = '0;
        // descending scan with >= leaves the lowest index on a tie
        for (int i = NUM_MASK - 1; i >= 0; i--) begin
            if (elig[i] && (!m_found || mask_prio[i*PRIO_W +: PRIO_W] >= m_best)) begin
                m_found = 1'b1;
                m_best  = mask_prio[i*PRIO_W +: PRIO_W];
                m_idx   = MIDX_W'(i);
            end
        end

        win = '0;
        if (|spec_req) begin
            win.hit = 1'b1;
            for (int s = NUM_SPEC - 1; s >= 0; s--) begin
                if (spec_req[s])
                    win.spec = spec_src_e'(s);
            end
        end else if (m_found) begin
            win.hit     = 1'b1;
            win.is_mask = 1'b1;
            win.midx    = m_idx;
            win.prio    = m_best;
        end
    end

endmodule

// File: rtl/irq_seq_timer.sv
module irq_seq_timer #(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             busy,
    output logic             last
);

    logic [CNT_W-1:0] remain;

    always_ff @(posedge clk) begin
        if (rst)
            remain <= '0;
        else if (load)
            remain <= load_val;
        else if (remain != '0)
            remain <= remain - 1'b1;
    end

    assign busy = (remain != '0);
    assign last = (remain == CNT_W'(1));

    // R9: the start pulse closes the sequence unless a fresh load arrives
    p_last_ends_r9: assert property (@(posedge clk) disable iff (rst)
        last && !load |=> !busy);

    // R10: no load can land while a sequence is running
    p_no_reload_r10: assert property (@(posedge clk) disable iff (rst)
        busy && !last |=> remain == $past(remain) - 1'b1);

endmodule

// File: rtl/irq_accept_seq.sv
module irq_accept_seq
    import irq_seq_pkg::*;
#(
    parameter  int NUM_MASK = 8,
    parameter  int BASE_CYC = 18,
    localparam int ID_W     = $clog2(NUM_SPEC + NUM_MASK)
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       insn_done,
    input  logic                       gie,
    input  logic [NUM_SPEC-1:0]        spec_req,
    input  logic [NUM_MASK-1:0]        mask_req,
    input  logic [NUM_MASK*PRIO_W-1:0] mask_prio,
    input  logic                       vec_odd,
    input  logic                       sp_odd,
    output logic                       busy,
    output logic                       ack,
    output logic [ID_W-1:0]            ack_id,
    output logic [PRIO_W-1:0]          ipl,
    output logic                       handler_start
);

    localparam int MAX_LEN = BASE_CYC + 4;
    localparam int CNT_W   = $clog2(MAX_LEN + 1);

    arb_win_t         win;
    logic             accept;
    logic [CNT_W-1:0] seq_len;
    prio_t            ipl_q;
    logic             ack_q;
    logic [ID_W-1:0]  id_q;

    irq_arbiter #(.NUM_MASK(NUM_MASK)) u_arb (
        .spec_req (spec_req),
        .mask_req (mask_req),
        .mask_prio(mask_prio),
        .gie      (gie),
        .cur_ipl  (ipl_q),
        .win      (win)
    );

    assign accept  = insn_done && !busy && win.hit;
    assign seq_len = CNT_W'(entry_len(BASE_CYC, vec_odd, sp_odd, win));

    irq_seq_timer #(.CNT_W(CNT_W)) u_tmr (
        .clk     (clk),
        .rst     (rst),
        .load    (accept),
        .load_val(seq_len),
        .busy    (busy),
        .last    (handler_start)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ipl_q <= '0;
            ack_q <= 1'b0;
            id_q  <= '0;
        end else begin
            ack_q <= accept;
            if (accept) begin
                id_q <= win.is_mask ? ID_W'(NUM_SPEC + int'(win.midx))
                                    : ID_W'(win.spec);
                case (win_class(win))
                    CLS_LOAD:  ipl_q <= win.prio;
                    CLS_FORCE: ipl_q <= PRIO_TOP;
                    default:   ipl_q <= ipl_q;
                endcase
            end
        end
    end

    assign ack    = ack_q;
    assign ack_id = id_q;
    assign ipl    = ipl_q;

    p_boundary_r1: assert property (@(posedge clk) disable iff (rst)
        ack |-> $past(insn_done) && !$past(busy));

    p_ack_opens_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> ack);

    p_mask_raises_r4: assert property (@(posedge clk) disable iff (rst)
        ack && int'(ack_id) >= NUM_SPEC |-> ipl > $past(ipl));

    p_force_top_r5: assert property (@(posedge clk) disable iff (rst)
        ack && int'(ack_id) <= int'(SRC_DROOP) |-> ipl == PRIO_TOP);

    p_keep_level_r6: assert property (@(posedge clk) disable iff (rst)
        ack && int'(ack_id) >= int'(SRC_DBG) && int'(ack_id) < NUM_SPEC
        |-> ipl == $past(ipl));

    p_ack_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        ack |=> !ack);

    p_quiet_in_seq_r10: assert property (@(posedge clk) disable iff (rst)
        busy && !handler_start |=> !ack && $stable(ipl));

    p_reset_idle_r11: assert property (@(posedge clk)
        rst |=> ipl == '0 && !busy && !ack && !handler_start);

endmodule

// File: tb/test_irq_accept_seq.sv
module test_irq_accept_seq;

    localparam int NM = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          insn_done = 1'b0;
    logic          gie = 1'b1;
    logic [7:0]    spec_req = '0;
    logic [NM-1:0] mask_req = '0;
    logic [NM*3-1:0] mask_prio = '0;
    logic          vec_odd = 1'b0;
    logic          sp_odd = 1'b0;
    logic          busy, ack, handler_start;
    logic [3:0]    ack_id;
    logic [2:0]    ipl;

    always #2 clk = ~clk;

    irq_accept_seq #(.NUM_MASK(NM), .BASE_CYC(18)) i_irq_accept_seq (
        .clk(clk), .rst(rst), .insn_done(insn_done), .gie(gie),
        .spec_req(spec_req), .mask_req(mask_req), .mask_prio(mask_prio),
        .vec_odd(vec_odd), .sp_odd(sp_odd), .busy(busy), .ack(ack),
        .ack_id(ack_id), .ipl(ipl), .handler_start(handler_start)
    );

    typedef struct { int id; int lvl; int len; string tag; } exp_t;
    exp_t sb[$];
    int   n_run = 0;
    int   n_bad = 0;
    bit   done  = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Monitor: pops one expectation per ack, counts busy cycles to the start pulse
    bit   in_seq = 0;
    int   cnt = 0;
    exp_t cur;
    always @(negedge clk) begin
        if (!rst) begin
            if (ack) begin
                if (sb.size() == 0) begin
                    chk(0, "R10/R7 unexpected ack", int'(ack_id), -1);
                end else begin
                    cur = sb.pop_front();
                    chk(int'(ack_id) == cur.id, {cur.tag, " R8 id"}, int'(ack_id), cur.id);
                    chk(int'(ipl) == cur.lvl, {cur.tag, " ipl"}, int'(ipl), cur.lvl);
                    in_seq = 1;
                    cnt = 0;
                end
            end
            if (in_seq) begin
                if (busy) cnt++;
                if (handler_start) begin
                    chk(cnt == cur.len, {cur.tag, " R2/R3 length"}, cnt, cur.len);
                    in_seq = 0;
                end else if (!busy) begin
                    chk(0, "R9 busy fell without handler_start", cnt, cur.len);
                    in_seq = 0;
                end
            end
        end
    end

    // insn_done low for w-1 cycles, then high for one; returns at the sample point
    task automatic boundary(input int w, output bit early);
        early = 0;
        for (int k = 0; k < w - 1; k++) begin
            insn_done = 1'b0;
            @(negedge clk);
            if (ack || busy) early = 1;
        end
        insn_done = 1'b1;
        @(negedge clk);
        insn_done = 1'b0;
    endtask

    task automatic take(input int id, input int lvl, input int len, input int w,
                        input string tag);
        bit early;
        exp_t e;
        e.id = id; e.lvl = lvl; e.len = len; e.tag = tag;
        sb.push_back(e);
        boundary(w, early);
        chk(!early, "R1 accepted before boundary", int'(early), 0);
        chk(ack == 1'b1, "R1 ack after boundary", int'(ack), 1);
        while (busy) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic refuse(input string tag);
        bit early;
        bit seen = 0;
        boundary(2, early);
        for (int k = 0; k < 25; k++) begin
            if (ack || busy) seen = 1;
            @(negedge clk);
        end
        chk(!seen && !early, tag, int'(seen), 0);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        chk(ipl == 3'd0 && !busy && !ack && !handler_start, "R11 reset state",
            int'(ipl), 0);
    endtask

    task automatic set_prio(input int i, input int p);
        mask_prio[i*3 +: 3] = 3'(p);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        do_reset();

        // R6 R2: software trap, even/even
        spec_req[7] = 1'b1;
        take(7, 0, 18, 3, "R6 trap");
        spec_req = '0;

        // R4 R2: maskable with one odd operand
        mask_req[0] = 1'b1; set_prio(0, 3); vec_odd = 1;
        take(8, 3, 19, 4, "R4 mask");
        mask_req = '0; vec_odd = 0;

        // R7: priority not above ipl is refused
        mask_req[1] = 1'b1; set_prio(1, 2);
        refuse("R7 low priority ignored");
        mask_req[1] = 1'b1; set_prio(1, 3);
        refuse("R7 equal priority ignored");

        // R8: highest priority wins, lowest index on tie; R2 both odd
        mask_req[2] = 1'b1; set_prio(2, 6);
        mask_req[3] = 1'b1; set_prio(3, 6);
        vec_odd = 1; sp_odd = 1;
        take(10, 6, 20, 2, "R8 mask tie");
        mask_req = '0; vec_odd = 0; sp_odd = 0;

        // R8 R5 R3: full chain, NMI behind a 30-cycle divide (R1)
        spec_req = 8'hFF; mask_req[0] = 1'b1; set_prio(0, 7);
        take(0, 7, 18, 30, "R5 nmi");
        spec_req[0] = 0; vec_odd = 1;
        take(1, 7, 19, 5, "R5 watchdog");
        spec_req[1] = 0; vec_odd = 0;
        take(2, 7, 18, 2, "R5 clock-stop");
        spec_req[2] = 0; sp_odd = 1;
        take(3, 7, 19, 2, "R5 droop");
        spec_req[3] = 0; vec_odd = 1;
        take(4, 7, 22, 2, "R3 debug break");
        spec_req[4] = 0; vec_odd = 0; sp_odd = 0;
        take(5, 7, 19, 2, "R3 single-step");
        spec_req[5] = 0; vec_odd = 1; sp_odd = 1;
        take(6, 7, 21, 2, "R3 address match");
        spec_req[6] = 0; vec_odd = 0; sp_odd = 0;
        take(7, 7, 18, 2, "R6 trap at level 7");
        spec_req = '0;
        refuse("R7 priority 7 at level 7 ignored");
        mask_req = '0;

        do_reset();

        // R7: gie low blocks maskable but not forcing sources
        gie = 0; mask_req[4] = 1'b1; set_prio(4, 7);
        refuse("R7 gie low ignored");
        spec_req[3] = 1'b1;
        take(3, 7, 18, 2, "R7 droop with gie low");
        spec_req = '0; mask_req = '0; gie = 1;

        do_reset();

        // R10: requests and boundaries during a sequence have no effect
        begin
            exp_t e;
            bit early;
            bit seen = 0;
            e.id = 7; e.lvl = 0; e.len = 18; e.tag = "R10 trap";
            sb.push_back(e);
            spec_req[7] = 1'b1;
            boundary(2, early);
            spec_req = '0;
            repeat (4) @(negedge clk);
            mask_req[0] = 1'b1; set_prio(0, 4);
            insn_done = 1'b1;
            @(negedge clk);
            insn_done = 1'b0;
            while (busy) @(negedge clk);
            for (int k = 0; k < 6; k++) begin
                if (ack || busy) seen = 1;
                @(negedge clk);
            end
            chk(!seen, "R10 pending held until boundary", int'(seen), 0);
        end
        take(8, 4, 18, 2, "R10 pending taken");
        mask_req = '0;

        repeat (4) @(negedge clk);
        chk(sb.size() == 0, "R9 scoreboard drained", sb.size(), 0);
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
        $finish;
    end

endmodule